// File: doc/BRIEF.md
# UART Control and Status Register File

This block is the software-facing register set of a small serial port. A 32-bit bus reaches five registers in a window of 0x50 bytes: a mode word, a status/control word, a baud divisor, a transmit data port and a receive data port. The mode, status and baud words each have three extra addresses that clear, set or toggle selected bits in one write, so software never needs a read-modify-write sequence.

Flags in the status word that describe the line are owned by hardware, and software writes leave them as they are. Turning the port off, or turning off the receiver or the transmitter, drives the status flags and interrupt requests to a consistent idle state. The shift engines and the baud generator sit outside. The receive side hands bytes in through a valid/ready pair into a one-entry buffer. The transmit side takes bytes out of a one-entry buffer through a valid/ready pair. Three level interrupt requests (receive, transmit, error) go to the interrupt controller.

Top module: `uart_csr_top`

## Requirements
- R1: After reset the mode and baud registers read 0, the status register reads 0x00000018 (receiver-idle bit 3 and transmit-empty bit 4 set), all three interrupt outputs are 0, txValid is 0 and rxReady is 0.
- R2: Register slots use address bits [6:4]: mode 0x00, status 0x10, transmit 0x20, receive 0x30, baud 0x40. Bits [3:2] select the operation: 0 plain write, 1 clear (+0x04), 2 set (+0x08), 3 invert (+0x0C). Addresses at or above 0x50 read 0 and writes there change nothing.
- R3: A write through the clear, set or invert address of mode, status or baud stores old AND NOT data, old OR data or old XOR data. The baud register keeps the low BAUD_W bits, 16 by default.
- R4: Reads of the transmit slot and of any clear/set/invert address return 0. Writes to the receive slot have no effect.
- R5: Status bits 0 (receive data available), 1 (parity error), 2 (framing error), 3 (receiver idle), 4 (transmit empty) and 9 (transmit buffer full) keep their values on any software write, plain or alias. All other status bits are stored from the write.
- R6: While the receiver enable (status bit 12) or ON (mode bit 15) is 0, rxIrq and errIrq are 0 and status bits 0, 1 and 2 read 0.
- R7: While the transmitter enable (status bit 10) or ON is 0, txIrq is 0, status bit 9 and txValid are 0, and status bit 4 reads 1.
- R8: While ON is 0, status bits 3 and 4 read 1, whatever the engine idle inputs are.
- R9: A received byte is accepted only while ON and receiver enable are 1 and the buffer is free (or is being read in the same cycle). Acceptance sets status bit 0 and rxIrq, and latches the byte's framing and parity error flags into bits 2 and 1. errIrq is the OR of bits 1 and 2.
- R10: A plain read of the receive slot returns the buffered byte. It empties the buffer and clears bit 0 and rxIrq, unless a new byte is accepted in the same cycle, in which case both stay set.
- R11: A transmit write while ON and transmitter enable are 1 raises txIrq, which holds until the transmitter or ON turns off. If the buffer is empty the write also loads txData and sets txValid and status bit 9. If the buffer is full the data is dropped. A txValid/txReady handshake empties the buffer.
- R12: While enabled, status bit 3 follows rxLineIdle and status bit 4 follows txShiftIdle one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte offset in the register window |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe (pops the receive buffer) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| rxValid | input | 1 | Receive engine offers a byte |
| rxData | input | CHAR_W | Offered byte |
| rxFrameErr | input | 1 | Offered byte had a framing error |
| rxParityErr | input | 1 | Offered byte had a parity error |
| rxReady | output | 1 | Byte is taken this cycle |
| rxLineIdle | input | 1 | Receive engine is idle |
| txValid | output | 1 | Transmit buffer holds a byte |
| txData | output | CHAR_W | Byte for the transmit engine |
| txReady | input | 1 | Transmit engine takes the byte |
| txShiftIdle | input | 1 | Transmit shift register is empty |
| modeOut | output | 32 | Current mode word |
| baudOut | output | BAUD_W | Current baud divisor |
| rxIrq | output | 1 | Receive interrupt request |
| txIrq | output | 1 | Transmit interrupt request |
| errIrq | output | 1 | Receive error interrupt request |

## Verification
A wrong hardware-owned flag shows up in the status read value and on an interrupt pin in the cycle after the event that should have set it. A missed disable cascade leaves rxIrq, txIrq or txValid high one clock after the write that cleared ON or an enable. A wrong alias decode corrupts the value read back right after the write. A receive-buffer fault shows up at the next receive read: a lost or repeated byte, or rxIrq staying high.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;

  localparam int REG_W = 32;

  // Mode word
  localparam int ON_BIT      = 15;
  // Status word: software-owned enables
  localparam int RXEN_BIT    = 12;
  localparam int TXEN_BIT    = 10;
  // Status word: hardware-owned flags
  localparam int RXAVAIL_BIT = 0;
  localparam int PERR_BIT    = 1;
  localparam int FERR_BIT    = 2;
  localparam int RXIDLE_BIT  = 3;
  localparam int TXEMPTY_BIT = 4;
  localparam int TXFULL_BIT  = 9;

  localparam logic [REG_W-1:0] HW_MASK =
    (REG_W'(1) << RXAVAIL_BIT) | (REG_W'(1) << PERR_BIT) |
    (REG_W'(1) << FERR_BIT)    | (REG_W'(1) << RXIDLE_BIT) |
    (REG_W'(1) << TXEMPTY_BIT) | (REG_W'(1) << TXFULL_BIT);
  localparam logic [REG_W-1:0] SW_MASK = ~HW_MASK;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_CLR   = 2'd1,
    OP_SET   = 2'd2,
    OP_INV   = 2'd3
  } aliasOp_e;

  typedef enum logic [2:0] {
    RD_ZERO = 3'd0,
    RD_MODE = 3'd1,
    RD_STAT = 3'd2,
    RD_BAUD = 3'd3,
    RD_RX   = 3'd4
  } rdSel_e;

  typedef struct packed {
    logic     wrMode;
    logic     wrStat;
    logic     wrBaud;
    logic     wrTx;
    logic     rdRx;
    aliasOp_e op;
    rdSel_e   rdSel;
  } csrStrobe_t;

  function automatic logic [REG_W-1:0] applyAlias(aliasOp_e op,
                                                  logic [REG_W-1:0] oldVal,
                                                  logic [REG_W-1:0] data);
    logic [REG_W-1:0] res;
    case (op)
      OP_CLR:  res = oldVal & ~data;
      OP_SET:  res = oldVal | data;
      OP_INV:  res = oldVal ^ data;
      default: res = data;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/uart_csr_decode.sv
module uart_csr_decode
  import uart_csr_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output csrStrobe_t        strobe
);

  localparam int SLOT_W     = ADDR_W - 4;
  localparam int WINDOW     = 'h50;
  localparam int SLOT_MODE  = 0;
  localparam int SLOT_STAT  = 1;
  localparam int SLOT_TX    = 2;
  localparam int SLOT_RX    = 3;
  localparam int SLOT_BAUD  = 4;

  logic [SLOT_W-1:0] slot;
  aliasOp_e          op;
  logic              inWindow;
  logic              isPlain;

  assign slot     = busAddr[ADDR_W-1:4];
  assign op       = aliasOp_e'(busAddr[3:2]);
  assign inWindow = (int'(busAddr) < WINDOW);
  assign isPlain  = (op == OP_WRITE);

  always_comb begin
    strobe        = '0;
    strobe.op     = op;
    strobe.rdSel  = RD_ZERO;
    if (inWindow) begin
      case (int'(slot))
        SLOT_MODE: begin
          strobe.wrMode = busWrEn;
          strobe.rdSel  = isPlain ? RD_MODE : RD_ZERO;
        end
        SLOT_STAT: begin
          strobe.wrStat = busWrEn;
          strobe.rdSel  = isPlain ? RD_STAT : RD_ZERO;
        end
        SLOT_TX: begin
          strobe.wrTx   = busWrEn & isPlain;
        end
        SLOT_RX: begin
          strobe.rdRx   = busRdEn & isPlain;
          strobe.rdSel  = isPlain ? RD_RX : RD_ZERO;
        end
        SLOT_BAUD: begin
          strobe.wrBaud = busWrEn;
          strobe.rdSel  = isPlain ? RD_BAUD : RD_ZERO;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/uart_csr_aliasreg.sv
module uart_csr_aliasreg
  import uart_csr_pkg::*;
#(
  parameter int           W    = 32,
  parameter logic [W-1:0] RST  = '0,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  aliasOp_e         op,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] oldView,
  output logic [W-1:0]     q,
  output logic [W-1:0]     nextQ
);

  logic [REG_W-1:0] merged;

  assign merged = applyAlias(op, oldView, wdata);

  always_comb begin
    nextQ = q;
    if (wrEn) nextQ = merged[W-1:0] & MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) q <= RST;
    else       q <= nextQ;
  end

endmodule

// File: rtl/uart_csr_datapath.sv
module uart_csr_datapath
  import uart_csr_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int BAUD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  csrStrobe_t        strobe,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxData,
  input  logic              rxFrameErr,
  input  logic              rxParityErr,
  output logic              rxReady,
  input  logic              rxLineIdle,
  output logic              txValid,
  output logic [CHAR_W-1:0] txData,
  input  logic              txReady,
  input  logic              txShiftIdle,
  output logic [REG_W-1:0]  modeQ,
  output logic [BAUD_W-1:0] baudQ,
  output logic [REG_W-1:0]  statusView,
  output logic              rxIrq,
  output logic              txIrq,
  output logic              errIrq
);

  logic [REG_W-1:0]  modeNext;
  logic [REG_W-1:0]  swStatQ, swStatNext;
  logic [BAUD_W-1:0] baudNext;

  logic [CHAR_W-1:0] rxBufQ, txBufQ;
  logic rxAvailQ, frameErrQ, parityErrQ, rxIdleQ;
  logic txEmptyQ, txFullQ, rxIrqQ, txIrqQ;

  logic onNow, rxEnNow, txEnNow;
  logic rxLive, txLive, onNext;
  logic rxPop, rxAccept, txLoad, txPop, txKick;

  // Configuration registers with alias operations
  uart_csr_aliasreg #(.W(REG_W), .RST('0), .MASK('1)) modeReg_i (
    .clk(clk), .rstN(rstN), .wrEn(strobe.wrMode), .op(strobe.op),
    .wdata(busWdata), .oldView(modeQ), .q(modeQ), .nextQ(modeNext)
  );

  uart_csr_aliasreg #(.W(REG_W), .RST('0), .MASK(SW_MASK)) statReg_i (
    .clk(clk), .rstN(rstN), .wrEn(strobe.wrStat), .op(strobe.op),
    .wdata(busWdata), .oldView(statusView), .q(swStatQ), .nextQ(swStatNext)
  );

  uart_csr_aliasreg #(.W(BAUD_W), .RST('0), .MASK('1)) baudReg_i (
    .clk(clk), .rstN(rstN), .wrEn(strobe.wrBaud), .op(strobe.op),
    .wdata(busWdata), .oldView(REG_W'(baudQ)), .q(baudQ), .nextQ(baudNext)
  );

  // Enables now and after this cycle's write
  assign onNow   = modeQ[ON_BIT];
  assign rxEnNow = swStatQ[RXEN_BIT];
  assign txEnNow = swStatQ[TXEN_BIT];
  assign onNext  = modeNext[ON_BIT];
  assign rxLive  = onNext & swStatNext[RXEN_BIT];
  assign txLive  = onNext & swStatNext[TXEN_BIT];

  // Handshakes
  assign rxPop    = strobe.rdRx & rxAvailQ;
  assign rxReady  = rxLive & (~rxAvailQ | rxPop);
  assign rxAccept = rxValid & rxReady;
  assign txKick   = strobe.wrTx & onNow & txEnNow;
  assign txLoad   = txKick & ~txFullQ;
  assign txPop    = txFullQ & txReady;

  // Receive side
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxBufQ     <= '0;
      rxAvailQ   <= 1'b0;
      rxIrqQ     <= 1'b0;
      frameErrQ  <= 1'b0;
      parityErrQ <= 1'b0;
      rxIdleQ    <= 1'b1;
    end else begin
      if (rxAccept) rxBufQ <= rxData;
      if (!rxLive) begin
        rxAvailQ   <= 1'b0;
        rxIrqQ     <= 1'b0;
        frameErrQ  <= 1'b0;
        parityErrQ <= 1'b0;
      end else if (rxAccept) begin
        rxAvailQ   <= 1'b1;
        rxIrqQ     <= 1'b1;
        frameErrQ  <= rxFrameErr;
        parityErrQ <= rxParityErr;
      end else if (rxPop) begin
        rxAvailQ   <= 1'b0;
        rxIrqQ     <= 1'b0;
      end
      rxIdleQ <= onNext ? rxLineIdle : 1'b1;
    end
  end

  // Transmit side
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBufQ   <= '0;
      txFullQ  <= 1'b0;
      txIrqQ   <= 1'b0;
      txEmptyQ <= 1'b1;
    end else begin
      if (txLoad) txBufQ <= busWdata[CHAR_W-1:0];
      if (!txLive) begin
        txFullQ  <= 1'b0;
        txIrqQ   <= 1'b0;
        txEmptyQ <= 1'b1;
      end else begin
        if (txLoad)      txFullQ <= 1'b1;
        else if (txPop)  txFullQ <= 1'b0;
        if (txKick)      txIrqQ  <= 1'b1;
        txEmptyQ <= txShiftIdle;
      end
    end
  end

  // Status view: software bits merged with hardware flags
  always_comb begin
    statusView              = swStatQ;
    statusView[RXAVAIL_BIT] = rxAvailQ;
    statusView[PERR_BIT]    = parityErrQ;
    statusView[FERR_BIT]    = frameErrQ;
    statusView[RXIDLE_BIT]  = rxIdleQ;
    statusView[TXEMPTY_BIT] = txEmptyQ;
    statusView[TXFULL_BIT]  = txFullQ;
  end

  always_comb begin
    case (strobe.rdSel)
      RD_MODE: busRdata = modeQ;
      RD_STAT: busRdata = statusView;
      RD_BAUD: busRdata = REG_W'(baudQ);
      RD_RX:   busRdata = REG_W'(rxBufQ);
      default: busRdata = '0;
    endcase
  end

  assign txValid = txFullQ;
  assign txData  = txBufQ;
  assign rxIrq   = rxIrqQ;
  assign txIrq   = txIrqQ;
  assign errIrq  = frameErrQ | parityErrQ;

endmodule

// File: rtl/uart_csr_top.sv
module uart_csr_top
  import uart_csr_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int CHAR_W = 8,
  parameter int BAUD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxData,
  input  logic              rxFrameErr,
  input  logic              rxParityErr,
  output logic              rxReady,
  input  logic              rxLineIdle,
  output logic              txValid,
  output logic [CHAR_W-1:0] txData,
  input  logic              txReady,
  input  logic              txShiftIdle,
  output logic [31:0]       modeOut,
  output logic [BAUD_W-1:0] baudOut,
  output logic              rxIrq,
  output logic              txIrq,
  output logic              errIrq
);

  csrStrobe_t       strobe;
  logic [REG_W-1:0] statusView;

  uart_csr_decode #(.ADDR_W(ADDR_W)) decode_i (
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn), .strobe(strobe)
  );

  uart_csr_datapath #(.CHAR_W(CHAR_W), .BAUD_W(BAUD_W)) datapath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .busRdata(busRdata), .rxValid(rxValid), .rxData(rxData),
    .rxFrameErr(rxFrameErr), .rxParityErr(rxParityErr), .rxReady(rxReady),
    .rxLineIdle(rxLineIdle), .txValid(txValid), .txData(txData),
    .txReady(txReady), .txShiftIdle(txShiftIdle), .modeQ(modeOut),
    .baudQ(baudOut), .statusView(statusView), .rxIrq(rxIrq),
    .txIrq(txIrq), .errIrq(errIrq)
  );

endmodule

// File: rtl/uart_csr_chk.sv
module uart_csr_chk
  import uart_csr_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [31:0]       busRdata,
  input logic              rxValid,
  input logic              rxReady,
  input logic              txValid,
  input logic [CHAR_W-1:0] txData,
  input logic              txReady,
  input logic [31:0]       modeOut,
  input logic [31:0]       statusView,
  input logic              rxIrq,
  input logic              txIrq,
  input logic              errIrq
);

  // R6
  rx_off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(modeOut[ON_BIT] && statusView[RXEN_BIT]) |->
      (!rxIrq && !errIrq && !statusView[RXAVAIL_BIT]));

  // R7
  tx_off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(modeOut[ON_BIT] && statusView[TXEN_BIT]) |->
      (!txIrq && !txValid && statusView[TXEMPTY_BIT]));

  // R8
  off_idle_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modeOut[ON_BIT] |-> (statusView[RXIDLE_BIT] && statusView[TXEMPTY_BIT]));

  // R9
  rx_accept_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxReady) |=> (rxIrq && statusView[RXAVAIL_BIT]));

  // R10
  rx_pop_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && int'(busAddr) == 'h30 && statusView[RXAVAIL_BIT] &&
     !(rxValid && rxReady)) |=> !rxIrq);

  // R11
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady && !busWrEn) |=> (txValid && $stable(txData)));

  // R4
  tx_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'(busAddr) >= 'h20 && int'(busAddr) < 'h30) |-> busRdata == 32'h0);

endmodule

bind uart_csr_top uart_csr_chk #(.ADDR_W(ADDR_W), .CHAR_W(CHAR_W)) chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busRdEn(busRdEn), .busRdata(busRdata), .rxValid(rxValid),
  .rxReady(rxReady), .txValid(txValid), .txData(txData), .txReady(txReady),
  .modeOut(modeOut), .statusView(statusView), .rxIrq(rxIrq),
  .txIrq(txIrq), .errIrq(errIrq)
);

// File: tb/uart_csr_top_tb_top.sv
module uart_csr_top_tb_top;

  localparam int ADDR_W = 7;
  localparam int CHAR_W = 8;
  localparam int BAUD_W = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWrEn = 1'b0;
  logic              busRdEn = 1'b0;
  logic [31:0]       busWdata = '0;
  logic [31:0]       busRdata;
  logic              rxValid = 1'b0;
  logic [CHAR_W-1:0] rxData = '0;
  logic              rxFrameErr = 1'b0;
  logic              rxParityErr = 1'b0;
  logic              rxReady;
  logic              rxLineIdle = 1'b1;
  logic              txValid;
  logic [CHAR_W-1:0] txData;
  logic              txReady = 1'b0;
  logic              txShiftIdle = 1'b1;
  logic [31:0]       modeOut;
  logic [BAUD_W-1:0] baudOut;
  logic              rxIrq, txIrq, errIrq;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  uart_csr_top #(.ADDR_W(ADDR_W), .CHAR_W(CHAR_W), .BAUD_W(BAUD_W)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWdata(busWdata), .busRdata(busRdata),
    .rxValid(rxValid), .rxData(rxData), .rxFrameErr(rxFrameErr),
    .rxParityErr(rxParityErr), .rxReady(rxReady), .rxLineIdle(rxLineIdle),
    .txValid(txValid), .txData(txData), .txReady(txReady),
    .txShiftIdle(txShiftIdle), .modeOut(modeOut), .baudOut(baudOut),
    .rxIrq(rxIrq), .txIrq(txIrq), .errIrq(errIrq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(int addr, logic [31:0] data);
    @(negedge clk);
    busAddr  = ADDR_W'(addr);
    busWdata = data;
    busWrEn  = 1'b1;
    @(negedge clk);
    busWrEn  = 1'b0;
    #1;
  endtask

  task automatic busRead(int addr, output logic [31:0] data);
    @(negedge clk);
    busAddr = ADDR_W'(addr);
    busRdEn = 1'b1;
    #1;
    data = busRdata;
    @(negedge clk);
    busRdEn = 1'b0;
    #1;
  endtask

  task automatic readCheck(string req, int addr, logic [31:0] exp);
    logic [31:0] v;
    busRead(addr, v);
    check(req, v, exp);
  endtask

  task automatic rxPush(logic [7:0] d, logic fe, logic pe);
    @(negedge clk);
    rxValid = 1'b1; rxData = d; rxFrameErr = fe; rxParityErr = pe;
    @(negedge clk);
    rxValid = 1'b0; rxFrameErr = 1'b0; rxParityErr = 1'b0;
    #1;
  endtask

  task automatic testReset();
    check("R1 irqs", {29'd0, rxIrq, txIrq, errIrq}, 32'h0);
    check("R1 txValid", {31'd0, txValid}, 32'h0);
    check("R1 rxReady", {31'd0, rxReady}, 32'h0);
    readCheck("R1 mode", 'h00, 32'h0);
    readCheck("R1 status", 'h10, 32'h18);
    readCheck("R1 baud", 'h40, 32'h0);
  endtask

  task automatic testAlias();
    busWrite('h40, 32'h0000_00F0);
    readCheck("R3 baud plain", 'h40, 32'h0000_00F0);
    busWrite('h48, 32'h0000_000F);
    readCheck("R3 baud set", 'h40, 32'h0000_00FF);
    busWrite('h44, 32'h0000_0033);
    readCheck("R3 baud clr", 'h40, 32'h0000_00CC);
    busWrite('h4C, 32'h0000_00FF);
    readCheck("R3 baud inv", 'h40, 32'h0000_0033);
    busWrite('h40, 32'h0001_2345);
    readCheck("R3 baud width", 'h40, 32'h0000_2345);
    check("R3 baudOut", {16'd0, baudOut}, 32'h2345);
    busWrite('h00, 32'h0000_A5A5);
    readCheck("R3 mode plain", 'h00, 32'h0000_A5A5);
    busWrite('h0C, 32'h0000_FFFF);
    readCheck("R3 mode inv", 'h00, 32'h0000_5A5A);
    busWrite('h00, 32'h0);
  endtask

  task automatic testWindow();
    busWrite('h50, 32'hFFFF_FFFF);
    busWrite('h60, 32'hFFFF_FFFF);
    busWrite('h7C, 32'hFFFF_FFFF);
    readCheck("R2 mode after out-of-window", 'h00, 32'h0);
    readCheck("R2 status after out-of-window", 'h10, 32'h18);
    readCheck("R2 baud after out-of-window", 'h40, 32'h2345);
    readCheck("R2 read 0x50", 'h50, 32'h0);
    readCheck("R2 read 0x7C", 'h7C, 32'h0);
    readCheck("R4 read tx", 'h20, 32'h0);
    readCheck("R4 read mode clr", 'h04, 32'h0);
    readCheck("R4 read stat set", 'h18, 32'h0);
    readCheck("R4 read baud inv", 'h4C, 32'h0);
    busWrite('h30, 32'h0000_00AB);
    readCheck("R4 rx write ignored", 'h30, 32'h0);
    readCheck("R4 status after rx write", 'h10, 32'h18);
  endtask

  task automatic testOwned();
    busWrite('h10, 32'hFFFF_FFFF);
    readCheck("R5 plain write all ones", 'h10, 32'hFFFF_FDF8);
    busWrite('h14, 32'hFFFF_FFFF);
    readCheck("R5 clr all", 'h10, 32'h0000_0018);
  endtask

  task automatic testRx();
    @(negedge clk);
    rxValid = 1'b1; rxData = 8'hEE;
    #1;
    check("R9 no accept while off", {31'd0, rxReady}, 32'h0);
    @(negedge clk);
    rxValid = 1'b0;
    readCheck("R9 status while off", 'h10, 32'h18);
    busWrite('h00, 32'h0000_8000);
    busWrite('h10, 32'h0000_1400);
    readCheck("R9 enabled status", 'h10, 32'h1418);
    rxPush(8'h5A, 1'b0, 1'b0);
    check("R9 rxIrq raised", {31'd0, rxIrq}, 32'h1);
    check("R9 buffer full blocks", {31'd0, rxReady}, 32'h0);
    readCheck("R9 status avail", 'h10, 32'h1419);
    busWrite('h18, 32'h0000_001F);
    readCheck("R5 set alias keeps owned", 'h10, 32'h1419);
    busWrite('h14, 32'h0000_021F);
    readCheck("R5 clr alias keeps owned", 'h10, 32'h1419);
    readCheck("R10 read byte", 'h30, 32'h5A);
    check("R10 rxIrq cleared", {31'd0, rxIrq}, 32'h0);
    readCheck("R10 status empty", 'h10, 32'h1418);
    rxPush(8'h11, 1'b0, 1'b0);
    @(negedge clk);
    busAddr = ADDR_W'('h30); busRdEn = 1'b1;
    rxValid = 1'b1; rxData = 8'h22;
    #1;
    check("R10 read during refill", busRdata, 32'h11);
    check("R9 ready during pop", {31'd0, rxReady}, 32'h1);
    @(negedge clk);
    busRdEn = 1'b0; rxValid = 1'b0;
    #1;
    check("R10 irq kept on refill", {31'd0, rxIrq}, 32'h1);
    readCheck("R10 refilled byte", 'h30, 32'h22);
    check("R10 irq cleared after last", {31'd0, rxIrq}, 32'h0);
    rxPush(8'h33, 1'b1, 1'b0);
    check("R9 errIrq on framing", {31'd0, errIrq}, 32'h1);
    readCheck("R9 framing flag", 'h10, 32'h141D);
    busWrite('h14, 32'h0000_1000);
    readCheck("R6 rx disable status", 'h10, 32'h0418);
    check("R6 irqs cleared", {30'd0, rxIrq, errIrq}, 32'h0);
    busWrite('h18, 32'h0000_1000);
    readCheck("R6 re-enable empty", 'h10, 32'h1418);
    @(negedge clk);
    rxLineIdle = 1'b0;
    readCheck("R12 rx idle follows", 'h10, 32'h1410);
    rxLineIdle = 1'b1;
    readCheck("R12 rx idle back", 'h10, 32'h1418);
  endtask

  task automatic testTx();
    txReady = 1'b0;
    busWrite('h20, 32'h0000_0041);
    check("R11 txValid", {31'd0, txValid}, 32'h1);
    check("R11 txData", {24'd0, txData}, 32'h41);
    check("R11 txIrq", {31'd0, txIrq}, 32'h1);
    readCheck("R11 full flag", 'h10, 32'h1618);
    busWrite('h20, 32'h0000_0042);
    check("R11 drop when full", {24'd0, txData}, 32'h41);
    @(negedge clk);
    txReady = 1'b1;
    @(negedge clk);
    txReady = 1'b0;
    #1;
    check("R11 handshake empties", {31'd0, txValid}, 32'h0);
    check("R11 irq holds", {31'd0, txIrq}, 32'h1);
    readCheck("R11 full flag cleared", 'h10, 32'h1418);
    @(negedge clk);
    txShiftIdle = 1'b0;
    readCheck("R12 tx empty follows", 'h10, 32'h1408);
    busWrite('h14, 32'h0000_0400);
    readCheck("R7 tx disable status", 'h10, 32'h1018);
    check("R7 txIrq cleared", {31'd0, txIrq}, 32'h0);
    busWrite('h20, 32'h0000_0055);
    check("R11 ignored when disabled", {30'd0, txValid, txIrq}, 32'h0);
    txShiftIdle = 1'b1;
  endtask

  task automatic testOff();
    busWrite('h18, 32'h0000_0400);
    readCheck("R7 tx re-enabled", 'h10, 32'h1418);
    rxPush(8'h77, 1'b0, 1'b1);
    check("R9 errIrq on parity", {31'd0, errIrq}, 32'h1);
    readCheck("R9 parity flag", 'h10, 32'h141B);
    txReady = 1'b0;
    busWrite('h20, 32'h0000_0099);
    check("R11 loaded before off", {31'd0, txValid}, 32'h1);
    @(negedge clk);
    rxLineIdle = 1'b0; txShiftIdle = 1'b0;
    busWrite('h04, 32'h0000_8000);
    readCheck("R8 mode cleared", 'h00, 32'h0);
    readCheck("R8 status when off", 'h10, 32'h1418);
    check("R8 irqs cleared", {29'd0, rxIrq, txIrq, errIrq}, 32'h0);
    check("R8 tx buffer cleared", {31'd0, txValid}, 32'h0);
    check("R8 rx not ready", {31'd0, rxReady}, 32'h0);
    rxLineIdle = 1'b1; txShiftIdle = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    testReset();
    testAlias();
    testWindow();
    testOwned();
    testRx();
    testTx();
    testOff();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule